// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one channel of a timer used in output mode. Each clock it compares the timer's shared counter value with its own compare value. From that result and a 3-bit mode field it drives an internal reference level. The reference can be left alone, set, cleared or inverted on a match. It can also be held at a fixed level, or shaped into a PWM waveform that takes the count direction into account. A polarity bit and a channel-enable bit turn the reference into the pin-level output.

The compare value is written through a single write port. When the preload bit of the mode byte is set, a write lands in a holding register and reaches the comparator only on the next update event. When the preload bit is clear, the write takes effect at once. Each new match raises a sticky match flag, and software clears that flag with a pulse. The interrupt output is the flag gated by an interrupt-enable bit. The counter itself is not part of this block: its value, its direction and the update event arrive as inputs.

Top module: `oc_channel`

## Requirements
- R1: After a synchronous reset the reference is low, the compare value is 0, the channel is disabled with polarity 0 (pin low), and both the match flag and the interrupt are low.
- R2: The reference mode is bits 6:4 of the byte written on the mode port. Code 0 (frozen) never changes the reference, even on a match.
- R3: In code 1 a match sets the reference high. In code 2 a match sets it low. Without a match, both codes hold the reference.
- R4: A match is the cycle in which the counter input first equals the compare value. A counter that stays equal produces no further match, so code 3 inverts the reference exactly once per match.
- R5: Code 4 holds the reference low and code 5 holds it high, whatever the counter does.
- R6: Code 6 (PWM first flavour): when counting up (cnt_down=0) the reference is high while counter < compare and low otherwise. When counting down it is low while counter > compare and high otherwise.
- R7: Code 7 is the inverse of code 6 in both directions.
- R8: With mode-byte bit 3 set, a compare write is held back until the next update_evt pulse and only then becomes the compare value.
- R9: With mode-byte bit 3 clear, a compare write is the compare value from the next cycle on.
- R10: Config bit 0 enables the channel and config bit 1 is the polarity. While enabled, the pin is the reference XOR polarity. While disabled, the pin equals the polarity bit, which is the inactive level. The reference is sampled one cycle after the counter, and the pin follows one cycle after the reference.
- R11: A match sets match_flag in the next cycle. A flag_clr pulse clears it unless a match occurs in the same cycle, in which case the match wins. irq is match_flag AND config bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | Count direction, 1 = down |
| update_evt | input | 1 | Update event pulse |
| mode_we | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte (bits 6:4 mode, bit 3 preload) |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value |
| cfg_we | input | 1 | Output config write strobe |
| cfg_wdata | input | 3 | Bit 0 enable, bit 1 polarity, bit 2 interrupt enable |
| flag_clr | input | 1 | Clears the match flag |
| pin_out | output | 1 | Pin-level output |
| match_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Compare interrupt |

## Verification
The bench holds the counter on the compare value for several cycles in toggle mode. A detector that fires on level instead of on the first equal cycle would flip the output on every cycle. It runs both PWM flavours across the compare boundary in each direction, where an off-by-one comparison or an ignored direction shows up at counter == compare. It writes a preloaded compare value and samples before and after the update pulse, which catches a design that bypasses the holding register. It also raises flag_clr in the same cycle as a match, where a design that lets the clear win would lose the event.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OCM_FROZEN  = 3'd0,
    OCM_SET     = 3'd1,
    OCM_CLEAR   = 3'd2,
    OCM_TOGGLE  = 3'd3,
    OCM_FORCE_LO = 3'd4,
    OCM_FORCE_HI = 3'd5,
    OCM_PWM_A   = 3'd6,
    OCM_PWM_B   = 3'd7
  } oc_mode_e;

  localparam int MODE_LSB    = 4;
  localparam int PRELOAD_BIT = 3;
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_POL_BIT = 1;
  localparam int CFG_IEN_BIT = 2;
endpackage

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         preload_en,
  input  logic         update_evt,
  output logic [W-1:0] cmp_active
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q   <= '0;
      cmp_active <= '0;
    end else begin
      if (wr_en) shadow_q <= wr_data;
      if (wr_en && !preload_en)
        cmp_active <= wr_data;
      else if (update_evt)
        cmp_active <= shadow_q;
    end
  end
endmodule

// File: rtl/oc_match_det.sv
module oc_match_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_val,
  input  logic         flag_clr,
  output logic         match_pulse,
  output logic         flag_q
);
  logic equal_now;
  logic equal_q;

  assign equal_now   = (cnt_val == cmp_val);
  assign match_pulse = equal_now && !equal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      equal_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      equal_q <= equal_now;
      if (match_pulse)   flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  oc_mode_e     mode,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_val,
  input  logic         cnt_down,
  input  logic         match,
  output logic         ref_q
);
  logic below, above, pwm_a, ref_d;

  assign below = (cnt_val < cmp_val);
  assign above = (cnt_val > cmp_val);
  assign pwm_a = cnt_down ? !above : below;

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      OCM_FROZEN:   ref_d = ref_q;
      OCM_SET:      if (match) ref_d = 1'b1;
      OCM_CLEAR:    if (match) ref_d = 1'b0;
      OCM_TOGGLE:   if (match) ref_d = !ref_q;
      OCM_FORCE_LO: ref_d = 1'b0;
      OCM_FORCE_HI: ref_d = 1'b1;
      OCM_PWM_A:    ref_d = pwm_a;
      OCM_PWM_B:    ref_d = !pwm_a;
      default:      ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_d;
  end
endmodule

// File: rtl/oc_pin_drive.sv
module oc_pin_drive #(
  parameter bit REG_PIN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic chan_en,
  input  logic chan_pol,
  output logic pin
);
  logic pin_d;

  assign pin_d = chan_en ? (ref_in ^ chan_pol) : chan_pol;

  generate
    if (REG_PIN) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else     pin <= pin_d;
      end
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign pin = pin_d;
    end
  endgenerate
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit REG_PIN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             update_evt,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_wdata,
  input  logic             flag_clr,
  output logic             pin_out,
  output logic             match_flag,
  output logic             irq
);
  logic [2:0]       mode_q;
  logic             preload_q;
  logic [2:0]       cfg_q;
  logic [CNT_W-1:0] cmp_act;
  logic             match_pulse;
  logic             ref_q;
  logic             chan_en, chan_pol, chan_ien;
  logic             unused_mode_bits;

  assign unused_mode_bits = ^{mode_wdata[7], mode_wdata[2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      preload_q <= 1'b0;
      cfg_q     <= '0;
    end else begin
      if (mode_we) begin
        mode_q    <= mode_wdata[MODE_LSB +: 3];
        preload_q <= mode_wdata[PRELOAD_BIT];
      end
      if (cfg_we) cfg_q <= cfg_wdata;
    end
  end

  assign chan_en  = cfg_q[CFG_EN_BIT];
  assign chan_pol = cfg_q[CFG_POL_BIT];
  assign chan_ien = cfg_q[CFG_IEN_BIT];

  oc_cmp_store #(.W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(cmp_we), .wr_data(cmp_wdata),
    .preload_en(preload_q), .update_evt(update_evt), .cmp_active(cmp_act)
  );

  oc_match_det #(.W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cmp_val(cmp_act),
    .flag_clr(flag_clr), .match_pulse(match_pulse), .flag_q(match_flag)
  );

  oc_ref_gen #(.W(CNT_W)) u_ref (
    .clk(clk), .rst(rst), .mode(oc_mode_e'(mode_q)), .cnt_val(cnt_val),
    .cmp_val(cmp_act), .cnt_down(cnt_down), .match(match_pulse), .ref_q(ref_q)
  );

  oc_pin_drive #(.REG_PIN(REG_PIN)) u_pin (
    .clk(clk), .rst(rst), .ref_in(ref_q), .chan_en(chan_en),
    .chan_pol(chan_pol), .pin(pin_out)
  );

  assign irq = match_flag && chan_ien;
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
  parameter int CNT_W   = 16,
  parameter bit REG_PIN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_down,
  input logic             update_evt,
  input logic [2:0]       mode,
  input logic             preload,
  input logic             cmp_we,
  input logic [CNT_W-1:0] cmp_wdata,
  input logic [CNT_W-1:0] cmp_act,
  input logic             match_pulse,
  input logic             ref_q,
  input logic             chan_en,
  input logic             chan_pol,
  input logic             flag_clr,
  input logic             match_flag,
  input logic             irq,
  input logic             pin_out
);
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0) |=> $stable(ref_q)); // R2
  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd1 && match_pulse) |=> ref_q); // R3
  AST_CLR_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && match_pulse) |=> !ref_q); // R3
  AST_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && match_pulse) |=> (ref_q != $past(ref_q))); // R4
  AST_NO_REPEAT_MATCH: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> !match_pulse || !$stable(cnt_val) || !$stable(cmp_act)); // R4
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) |=> !ref_q); // R5
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd5) |=> ref_q); // R5
  AST_PWM_A_UP: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd6 && !cnt_down && cnt_val < cmp_act) |=> ref_q); // R6
  AST_PWM_A_DOWN: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd6 && cnt_down && cnt_val > cmp_act) |=> !ref_q); // R6
  AST_PWM_B_UP: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd7 && !cnt_down && cnt_val < cmp_act) |=> !ref_q); // R7
  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (preload && cmp_we && !update_evt) |=> $stable(cmp_act)); // R8
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!preload && cmp_we) |=> (cmp_act == $past(cmp_wdata))); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> match_flag); // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !match_pulse) |=> !match_flag); // R11
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> match_flag); // R11

  generate
    if (REG_PIN) begin : g_pin_chk
      AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (pin_out == $past(chan_pol))); // R10
      AST_PIN_ENABLED: assert property (@(posedge clk) disable iff (rst)
        chan_en |=> (pin_out == $past(ref_q ^ chan_pol))); // R10
    end
  endgenerate
endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W), .REG_PIN(REG_PIN)) u_chk (
  .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down),
  .update_evt(update_evt), .mode(mode_q), .preload(preload_q),
  .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_act(cmp_act),
  .match_pulse(match_pulse), .ref_q(ref_q), .chan_en(chan_en),
  .chan_pol(chan_pol), .flag_clr(flag_clr), .match_flag(match_flag),
  .irq(irq), .pin_out(pin_out)
);

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] cnt_val;
  logic         cnt_down, update_evt, mode_we, cmp_we, cfg_we, flag_clr;
  logic [7:0]   mode_wdata;
  logic [W-1:0] cmp_wdata;
  logic [2:0]   cfg_wdata;
  logic         pin_out, match_flag, irq;

  oc_channel #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .update_evt(update_evt), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .flag_clr(flag_clr), .pin_out(pin_out),
    .match_flag(match_flag), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    due;
    int    sel;
    logic  val;
    string tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares due items away from the active edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic act;
        act = (sb[i].sel == 0) ? pin_out : (sb[i].sel == 1) ? match_flag : irq;
        n_checks++;
        if (act !== sb[i].val) begin
          n_fail++;
          $display("FAIL %s: %s actual=%b expected=%b", sb[i].tag,
                   (sb[i].sel == 0) ? "pin" : (sb[i].sel == 1) ? "flag" : "irq",
                   act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_v(string tag, int sel, logic val, int lat);
    item_t it;
    it.due = cyc + lat; it.sel = sel; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // counter sample whose reference reaches the pin two edges later
  task automatic drive_pin(string tag, logic [W-1:0] c, logic dn, logic exp_pin);
    cnt_val = c; cnt_down = dn;
    expect_v(tag, 0, exp_pin, 2);
    step();
  endtask

  task automatic settle();
    step(); step(); step();
  endtask

  task automatic wr_mode(logic [7:0] v);
    mode_we = 1'b1; mode_wdata = v; step(); mode_we = 1'b0; settle();
  endtask

  task automatic wr_cmp(logic [W-1:0] v);
    cmp_we = 1'b1; cmp_wdata = v; step(); cmp_we = 1'b0; settle();
  endtask

  task automatic wr_cfg(logic [2:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step(); cfg_we = 1'b0; settle();
  endtask

  initial begin
    rst = 1'b1; cnt_val = '1; cnt_down = 1'b0; update_evt = 1'b0;
    mode_we = 1'b0; mode_wdata = '0; cmp_we = 1'b0; cmp_wdata = '0;
    cfg_we = 1'b0; cfg_wdata = '0; flag_clr = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    expect_v("R1 reset", 0, 1'b0, 1);
    expect_v("R1 reset", 1, 1'b0, 1);
    expect_v("R1 reset", 2, 1'b0, 1);
    step(); step();

    wr_cfg(3'b101);  // enable, polarity 0, interrupt enable

    // R3/R9: set on match, direct compare write
    wr_mode(8'h10);
    wr_cmp(16'd100);
    drive_pin("R3 set idle", 16'd50, 1'b0, 1'b0);
    cnt_val = 16'd100; expect_v("R3 set match", 0, 1'b1, 2);
    expect_v("R11 flag on match", 1, 1'b1, 1);
    expect_v("R11 irq on match", 2, 1'b1, 1);
    step();
    drive_pin("R3 set hold", 16'd101, 1'b0, 1'b1);
    flag_clr = 1'b1; expect_v("R11 flag clear", 1, 1'b0, 1); step(); flag_clr = 1'b0;

    // R3: clear on match
    wr_mode(8'h20);
    drive_pin("R3 clr idle", 16'd50, 1'b0, 1'b1);
    drive_pin("R3 clr match", 16'd100, 1'b0, 1'b0);

    // R4: toggle once per match
    wr_mode(8'h30);
    drive_pin("R4 toggle idle", 16'd99, 1'b0, 1'b0);
    drive_pin("R4 toggle match", 16'd100, 1'b0, 1'b1);
    drive_pin("R4 held equal", 16'd100, 1'b0, 1'b1);
    drive_pin("R4 held equal", 16'd100, 1'b0, 1'b1);
    drive_pin("R4 leave", 16'd101, 1'b0, 1'b1);
    drive_pin("R4 second match", 16'd100, 1'b0, 1'b0);
    drive_pin("R4 away", 16'd5, 1'b0, 1'b0);
    drive_pin("R4 third match", 16'd100, 1'b0, 1'b1);

    // R2: frozen keeps a high reference through a match
    wr_mode(8'h00);
    drive_pin("R2 frozen away", 16'd5, 1'b0, 1'b1);
    drive_pin("R2 frozen match", 16'd100, 1'b0, 1'b1);
    drive_pin("R2 frozen after", 16'd5, 1'b0, 1'b1);

    // R5: forced levels
    wr_mode(8'h40);
    drive_pin("R5 force low", 16'd100, 1'b0, 1'b0);
    wr_mode(8'h50);
    drive_pin("R5 force high", 16'd7, 1'b0, 1'b1);

    // R6: PWM first flavour
    wr_mode(8'h60);
    drive_pin("R6 up below", 16'd99, 1'b0, 1'b1);
    drive_pin("R6 up equal", 16'd100, 1'b0, 1'b0);
    drive_pin("R6 up above", 16'd150, 1'b0, 1'b0);
    drive_pin("R6 down above", 16'd150, 1'b1, 1'b0);
    drive_pin("R6 down equal", 16'd100, 1'b1, 1'b1);
    drive_pin("R6 down below", 16'd20, 1'b1, 1'b1);

    // R7: PWM second flavour
    wr_mode(8'h70);
    drive_pin("R7 up below", 16'd99, 1'b0, 1'b0);
    drive_pin("R7 up equal", 16'd100, 1'b0, 1'b1);
    drive_pin("R7 down above", 16'd101, 1'b1, 1'b1);
    drive_pin("R7 down equal", 16'd100, 1'b1, 1'b0);

    // R8: preloaded compare waits for update
    wr_mode(8'h68);
    wr_cmp(16'd200);
    drive_pin("R8 before update", 16'd150, 1'b0, 1'b0);
    update_evt = 1'b1; step(); update_evt = 1'b0;
    drive_pin("R8 after update", 16'd150, 1'b0, 1'b1);

    // R9: direct compare write
    wr_mode(8'h60);
    wr_cmp(16'd120);
    drive_pin("R9 direct below", 16'd110, 1'b0, 1'b1);
    drive_pin("R9 direct above", 16'd130, 1'b0, 1'b0);

    // R10: polarity and enable
    wr_mode(8'h50);
    expect_v("R10 en pol0", 0, 1'b1, 1); step();
    wr_cfg(3'b111); expect_v("R10 en pol1", 0, 1'b0, 1); step();
    wr_cfg(3'b110); expect_v("R10 off pol1", 0, 1'b1, 1); step();
    wr_cfg(3'b100); expect_v("R10 off pol0", 0, 1'b0, 1); step();
    wr_cfg(3'b101); expect_v("R10 en again", 0, 1'b1, 1); step();

    // R11: interrupt gating and match-wins-over-clear
    cnt_val = 16'd5;
    flag_clr = 1'b1; expect_v("R11 pre clear", 1, 1'b0, 1); step(); flag_clr = 1'b0;
    wr_cfg(3'b001);
    cnt_val = 16'd120;
    expect_v("R11 flag ien0", 1, 1'b1, 1);
    expect_v("R11 irq masked", 2, 1'b0, 1);
    step();
    cnt_val = 16'd121;
    flag_clr = 1'b1; expect_v("R11 clear", 1, 1'b0, 1); step(); flag_clr = 1'b0;
    wr_cfg(3'b101);
    cnt_val = 16'd5; step();
    cnt_val = 16'd120; flag_clr = 1'b1;
    expect_v("R11 match wins", 1, 1'b1, 1);
    expect_v("R11 irq set", 2, 1'b1, 1);
    step(); flag_clr = 1'b0;

    repeat (4) step();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    if (sb.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule